// File: doc/BRIEF.md
# Pipelined Reciprocal Unit for Triangle Setup

This block computes the fixed-point reciprocal of a 16-bit unsigned divisor so that a triangle setup engine can form edge slopes and the per-pixel increments for color, depth and texture coordinates by multiplying rather than dividing. It is fully pipelined. One operand enters on any clock, and its result leaves exactly ten clocks later. This lets setup keep pace with a rasterizer that emits one pixel per clock.

Inside, the divisor is first normalized by a leading-zero count into the range [1, 2). The bits just below its leading one address a small computed table that gives an 8-bit starting estimate. Two unrolled Newton-Raphson refinements, each computing x·(2 − b·x), then sharpen the estimate. The datapath keeps four guard bits below the output precision. A final stage undoes the normalization shift and rounds the value. A zero divisor is flagged and gives a saturated result.

Top module: `recip_nr_top`

## Requirements
- R1: While reset is held and on the first clocks after it is released, `out_valid` is 0.
- R2: A divisor presented with `in_valid` high at a rising edge produces `out_valid` high exactly 10 rising edges later, together with its result and flag.
- R3: Divisors presented on consecutive clocks give results on consecutive clocks, in the order they were presented.
- R4: For every nonzero divisor d, `out_recip` is an unsigned number with 1 integer bit and 16 fraction bits (17 bits wide), and it lies within 1 unit in the last place of 65536/d, that is |out_recip·d − 65536| ≤ d.
- R5: A zero divisor gives `out_dz` = 1 and `out_recip` = 17'h1FFFF, on the same clock as its `out_valid`.
- R6: A nonzero divisor gives `out_dz` = 0.
- R7: A clock with `in_valid` low produces no result, so gaps in the input stream appear as the same gaps at the output.
- R8: For a divisor that is a power of two, 2^k with k from 0 to 15, `out_recip` equals 65536/2^k exactly.
- R9: Reset asserted while results are in flight discards them all, and none of them appears after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Divisor on `in_div` is to be processed |
| in_div | input | 16 | Unsigned divisor |
| out_valid | output | 1 | Result and flag are valid |
| out_recip | output | 17 | Reciprocal, 1 integer and 16 fraction bits |
| out_dz | output | 1 | Divisor was zero |

## Verification
The bench sweeps every divisor value from 0 to 65535 back-to-back. This exposes any table entry or normalization shift that loses accuracy: such an error would put a result more than one unit off. The powers of two are checked for exact results, because a design that truncated instead of rounding would return one unit low there. Divisor 1 is the widest case, since its result needs the 17th bit and would wrap to zero if that bit were dropped. Separately, the bench inserts input gaps and applies a reset in the middle of a stream. A valid bit that leaked, or that was not cleared by reset, would show up as an extra or misplaced output.

// File: rtl/recip_pkg.sv
// Package: shared widths, control record and seed computation for the
// reciprocal pipeline. Assumes a Q1.(DIV_W-1) normalized divisor.
package recip_pkg;
    localparam int DIV_W   = 16;              // divisor width
    localparam int OUT_F   = 16;              // output fraction bits
    localparam int GUARD   = 4;               // guard bits kept internally
    localparam int XF      = OUT_F + GUARD;   // estimate fraction bits
    localparam int XW      = XF + 1;          // estimate width, Q1.XF
    localparam int TW      = XF + 2;          // product / correction width
    localparam int RES_W   = OUT_F + 1;       // result width, Q1.OUT_F
    localparam int SH_W    = $clog2(DIV_W);   // normalization shift width
    localparam int ROM_IDX = 6;               // seed table index bits
    localparam int ROM_N   = 1 << ROM_IDX;    // seed table entries
    localparam int SEED_W  = 8;               // seed width, Q0.SEED_W
    localparam int NR_ITER = 2;               // refinement steps
    localparam int SH_BASE = XF - OUT_F + DIV_W - 2; // denorm shift keeping one half bit

    typedef struct packed {
        logic            valid;
        logic            zero;
        logic [SH_W-1:0] lz;
    } ctl_t;

    // Seed = rounded 1/b at the midpoint of table interval i, as Q0.SEED_W.
    function automatic logic [SEED_W-1:0] seed_val(input int i);
        int den;
        int num;
        int q;
        den = (1 << (ROM_IDX + 1)) + 2 * i + 1;
        num = (1 << SEED_W) * (1 << (ROM_IDX + 1));
        q   = (num + den / 2) / den;
        if (q > (1 << SEED_W) - 1) q = (1 << SEED_W) - 1;
        return SEED_W'(q);
    endfunction
endpackage

// File: rtl/recip_normalize.sv
// Stage 1: counts leading zeros of the divisor and shifts it so its top bit
// is set (b in [1,2) as Q1.DIV_W-1). Assumes nothing about the input value;
// a zero divisor is marked and its shift is left at zero.
module recip_normalize
    import recip_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [DIV_W-1:0] in_div,
    output ctl_t             ctl_o,
    output logic [DIV_W-1:0] b_o
);
    logic [SH_W-1:0] lz_c;

    // Leading-zero count: the highest set bit wins.
    always_comb begin
        lz_c = '0;
        for (int i = 0; i < DIV_W; i++) begin
            if (in_div[i]) lz_c = SH_W'(DIV_W - 1 - i);
        end
    end

    // Register the valid bit under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_o.valid <= 1'b0;
        else        ctl_o.valid <= in_valid;
    end

    // Register the normalized divisor and its side information.
    always_ff @(posedge clk) begin
        ctl_o.zero <= (in_div == '0);
        ctl_o.lz   <= lz_c;
        b_o        <= in_div << lz_c;
    end

    p_norm_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o.valid && !ctl_o.zero) |-> b_o[DIV_W-1]);
endmodule

// File: rtl/recip_seed_rom.sv
// Stage 2: looks up the starting estimate of 1/b from a table indexed by the
// ROM_IDX bits below the leading one. Table contents are computed from the
// interval midpoints. Assumes b_i is normalized (top bit set).
module recip_seed_rom
    import recip_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_t             ctl_i,
    input  logic [DIV_W-1:0] b_i,
    output ctl_t             ctl_o,
    output logic [DIV_W-1:0] b_o,
    output logic [XW-1:0]    x_o
);
    logic [SEED_W-1:0]  rom [ROM_N];
    logic [ROM_IDX-1:0] idx;

    for (genvar g = 0; g < ROM_N; g++) begin : g_rom
        assign rom[g] = seed_val(g);
    end

    assign idx = b_i[DIV_W-2 -: ROM_IDX];

    // Valid bit advances under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_o.valid <= 1'b0;
        else        ctl_o.valid <= ctl_i.valid;
    end

    // Seed widened to Q1.XF; divisor and side data carried along.
    always_ff @(posedge clk) begin
        ctl_o.zero <= ctl_i.zero;
        ctl_o.lz   <= ctl_i.lz;
        b_o        <= b_i;
        x_o        <= XW'(rom[idx]) << (XF - SEED_W);
    end

    p_seed_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o.valid && !ctl_o.zero) |->
            (x_o <= XW'(1 << XF)) && (x_o >= XW'(1 << (XF - 1))));
endmodule

// File: rtl/recip_nr_step.sv
// One Newton-Raphson refinement x' = x*(2 - b*x) over three registered
// stages: multiply b*x, subtract from two, multiply by x. Assumes x <= 1/b
// or slightly above it, so the product b*x stays below two.
module recip_nr_step
    import recip_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_t             ctl_i,
    input  logic [DIV_W-1:0] b_i,
    input  logic [XW-1:0]    x_i,
    output ctl_t             ctl_o,
    output logic [DIV_W-1:0] b_o,
    output logic [XW-1:0]    x_o
);
    ctl_t                  ctl_a, ctl_b;
    logic [DIV_W-1:0]      b_a, b_b;
    logic [XW-1:0]         x_a, x_b;
    logic [TW-1:0]         p_a, t_b;
    logic [DIV_W+XW-1:0]   bx_prod;
    logic [XW+TW-1:0]      xt_prod;

    assign bx_prod = b_i * x_i;
    assign xt_prod = x_b * t_b;

    // Valid bits of the three sub-stages under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_a.valid <= 1'b0;
            ctl_b.valid <= 1'b0;
            ctl_o.valid <= 1'b0;
        end else begin
            ctl_a.valid <= ctl_i.valid;
            ctl_b.valid <= ctl_a.valid;
            ctl_o.valid <= ctl_b.valid;
        end
    end

    // Sub-stage A: product b*x scaled to Q2.XF.
    always_ff @(posedge clk) begin
        ctl_a.zero <= ctl_i.zero;
        ctl_a.lz   <= ctl_i.lz;
        b_a        <= b_i;
        x_a        <= x_i;
        p_a        <= bx_prod[DIV_W-1 +: TW];
    end

    // Sub-stage B: correction factor 2 - b*x.
    always_ff @(posedge clk) begin
        ctl_b.zero <= ctl_a.zero;
        ctl_b.lz   <= ctl_a.lz;
        b_b        <= b_a;
        x_b        <= x_a;
        t_b        <= TW'(2 << XF) - p_a;
    end

    // Sub-stage C: refined estimate x*(2 - b*x), truncated to Q1.XF.
    always_ff @(posedge clk) begin
        ctl_o.zero <= ctl_b.zero;
        ctl_o.lz   <= ctl_b.lz;
        b_o        <= b_b;
        x_o        <= xt_prod[XF +: XW];
    end

    p_prod_below_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_a.valid && !ctl_a.zero) |-> (p_a < TW'(2 << XF)));
    p_est_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o.valid && !ctl_o.zero) |-> (x_o <= XW'(1 << XF)));
endmodule

// File: rtl/recip_denorm.sv
// Two stages: undo the normalization shift keeping one half bit, then round
// to OUT_F fraction bits and apply the zero-divisor saturation. Assumes the
// estimate is at most 1.0.
module recip_denorm
    import recip_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_t             ctl_i,
    input  logic [XW-1:0]    x_i,
    output logic             out_valid,
    output logic [RES_W-1:0] out_recip,
    output logic             out_dz
);
    logic             v_s, z_s;
    logic [RES_W:0]   half_s;
    logic [XW-1:0]    shifted;
    logic [SH_W:0]    sh_amt;

    assign sh_amt  = (SH_W + 1)'(SH_BASE) - (SH_W + 1)'(ctl_i.lz);
    assign shifted = x_i >> sh_amt;

    // Valid bits of both stages under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_s       <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            v_s       <= ctl_i.valid;
            out_valid <= v_s;
        end
    end

    // Denormalize: value scaled to OUT_F+1 fraction bits.
    always_ff @(posedge clk) begin
        z_s    <= ctl_i.zero;
        half_s <= shifted[RES_W:0];
    end

    // Round half up, or saturate for a zero divisor.
    always_ff @(posedge clk) begin
        out_dz    <= z_s;
        out_recip <= z_s ? '1 : RES_W'((half_s + 1'b1) >> 1);
    end

    p_result_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_dz) |->
            (out_recip != '0) && (out_recip <= RES_W'(1 << OUT_F)));
endmodule

// File: rtl/recip_nr_top.sv
// Top: ten-stage reciprocal pipeline. Stage 1 normalize, stage 2 seed,
// stages 3-8 two refinements, stages 9-10 denormalize and round.
// Accepts one divisor per clock; no backpressure.
module recip_nr_top
    import recip_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [DIV_W-1:0] in_div,
    output logic             out_valid,
    output logic [RES_W-1:0] out_recip,
    output logic             out_dz
);
    ctl_t             ctl_n;
    logic [DIV_W-1:0] b_n;
    ctl_t             ctl_c [NR_ITER+1];
    logic [DIV_W-1:0] b_c   [NR_ITER+1];
    logic [XW-1:0]    x_c   [NR_ITER+1];

    recip_normalize u_norm (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_div(in_div),
        .ctl_o(ctl_n), .b_o(b_n)
    );

    recip_seed_rom u_seed (
        .clk(clk), .rst_n(rst_n), .ctl_i(ctl_n), .b_i(b_n),
        .ctl_o(ctl_c[0]), .b_o(b_c[0]), .x_o(x_c[0])
    );

    for (genvar k = 0; k < NR_ITER; k++) begin : g_nr
        recip_nr_step u_step (
            .clk(clk), .rst_n(rst_n),
            .ctl_i(ctl_c[k]), .b_i(b_c[k]), .x_i(x_c[k]),
            .ctl_o(ctl_c[k+1]), .b_o(b_c[k+1]), .x_o(x_c[k+1])
        );
    end

    recip_denorm u_denorm (
        .clk(clk), .rst_n(rst_n), .ctl_i(ctl_c[NR_ITER]), .x_i(x_c[NR_ITER]),
        .out_valid(out_valid), .out_recip(out_recip), .out_dz(out_dz)
    );

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##10 out_valid);
    p_gap_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##10 !out_valid);
    p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_div == '0) |-> ##10 (out_dz && out_recip == '1));
    p_nonzero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_div != '0) |-> ##10 !out_dz);
endmodule

// File: tb/recip_nr_top_tb.sv
module recip_nr_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_div = '0;
    logic        out_valid;
    logic [16:0] out_recip;
    logic        out_dz;

    int checks = 0;
    int errors = 0;
    longint cyc = 0;
    bit done = 0;

    typedef struct { int d; longint due; } item_t;
    item_t sb[$];

    recip_nr_top u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_div(in_div),
        .out_valid(out_valid), .out_recip(out_recip), .out_dz(out_dz)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) if (cyc > 190000) begin
        errors++;
        $display("FAIL watchdog: run hung at cycle %0d, expected end before 190000", cyc);
        finish_run();
    end

    // Driver: one slot per clock, pushes the expected item.
    task automatic drive(input bit v, input int d);
        @(posedge clk); #1;
        in_valid = v;
        in_div = 16'(d);
        if (v) sb.push_back('{d: d, due: cyc + 10});
    endtask

    // Monitor: compares outputs against the scoreboard.
    always @(negedge clk) if (rst_n) begin
        if (out_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R7/R9: unexpected out_valid=1, expected 0 at cycle %0d", cyc);
            end else begin
                item_t it;
                longint diff;
                it = sb.pop_front();
                if (cyc != it.due) begin
                    errors++;
                    $display("FAIL R2/R3: d=%0d arrived cycle %0d expected %0d", it.d, cyc, it.due);
                end
                if (it.d == 0) begin
                    if (!out_dz || out_recip != 17'h1FFFF) begin
                        errors++;
                        $display("FAIL R5: d=0 dz=%0b res=%h expected dz=1 res=1ffff", out_dz, out_recip);
                    end
                end else begin
                    if (out_dz) begin
                        errors++;
                        $display("FAIL R6: d=%0d dz=1 expected 0", it.d);
                    end
                    diff = longint'(out_recip) * it.d - 65536;
                    if (diff < 0) diff = -diff;
                    if (diff > it.d) begin
                        errors++;
                        $display("FAIL R4: d=%0d res=%0d expected ~%0d", it.d, out_recip, 65536 / it.d);
                    end
                    if ((it.d & (it.d - 1)) == 0 && out_recip != 17'(65536 / it.d)) begin
                        errors++;
                        $display("FAIL R8: d=%0d res=%0d expected %0d", it.d, out_recip, 65536 / it.d);
                    end
                end
            end
        end else if (sb.size() != 0 && sb[0].due <= cyc) begin
            checks++;
            errors++;
            $display("FAIL R2: d=%0d missing, out_valid=0 expected 1 at cycle %0d", sb[0].d, cyc);
            void'(sb.pop_front());
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: out_valid=%b during reset expected 0", out_valid);
        end
        @(posedge clk); #1 rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0) begin
                errors++;
                $display("FAIL R1: out_valid=%b after reset expected 0", out_valid);
            end
        end

        // R8 and R5 boundaries first, then R4/R3 exhaustive back-to-back sweep
        for (int k = 0; k < 16; k++) drive(1, 1 << k);
        drive(1, 0);
        drive(1, 65535);
        drive(1, 3);
        for (int d = 0; d < 65536; d++) drive(1, d);

        // R7: sparse stream with gaps
        for (int i = 0; i < 60; i++) drive((i % 3) == 0, 1 + i * 997);
        drive(0, 0);
        repeat (14) drive(0, 0);

        // R9: reset with results in flight
        for (int i = 0; i < 8; i++) drive(1, 100 + i);
        @(posedge clk); #1;
        in_valid = 1'b0;
        rst_n = 1'b0;
        sb.delete();
        @(posedge clk); #1 rst_n = 1'b1;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0) begin
                errors++;
                $display("FAIL R9: out_valid=%b after mid-stream reset expected 0", out_valid);
            end
        end

        // R2 after reset: pipeline still works
        drive(1, 7);
        drive(1, 0);
        drive(0, 0);
        repeat (14) drive(0, 0);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R2: %0d results outstanding expected 0", sb.size());
        end
        finish_run();
    end
endmodule